// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block produces MAC control PAUSE frames for a gigabit transmit path, one byte per clock. A request to pause the link partner can come from a level flow-control pin, when it rises, or from a one-cycle software trigger. When the pin falls, a frame carrying a zero pause time follows, so the partner may resume; a register bit can suppress that frame. Requests that arrive while the MAC is busy with a data packet, or while a pause frame is already going out, are held in a single pending slot. A newer request overwrites an older one, and the slot is served as soon as the path is free.

The frame is built on the fly from fixed protocol constants, the station address input and the captured pause time. The block appends the Ethernet CRC-32 and presents the bytes on a valid/ready stream with a last marker. A countdown timer models the pause period still left at the partner, measured in 64-cycle quanta from the end of each frame. When refresh mode is on, the pin is still high and the count reaches a programmable lead value, the block sends a fresh pause frame before the partner's period expires.

Top module: `pause_gen`

## Requirements
- R1: While reset is asserted, and after its release until a request is made, `tx_valid` stays low.
- R2: Each frame is 64 bytes long. Bytes 0 to 5 are 01 80 C2 00 00 01. Bytes 6 to 11 are `station_mac`, bits 47:40 first. Bytes 12 to 15 are 88 08 00 01. Bytes 16 and 17 are the pause time, high byte first. Bytes 18 to 59 are zero. `tx_valid` stays high from the first byte until the last byte is accepted.
- R3: Bytes 60 to 63 hold the complement of a CRC-32 (reflected polynomial 0xEDB88320, start value all ones) taken over bytes 0 to 59, least significant byte first. `tx_last` is high only while byte 63 is offered.
- R4: A rising edge of `fc_level` seen at a clock edge, or `sw_pause` high at a clock edge, requests a frame that carries the `pause_quanta` value at that edge. If the block is idle and `mac_busy` is low, `tx_valid` rises after the following clock edge.
- R5: A falling edge of `fc_level` requests a frame with a pause time of zero when `xon_off` is 0. When `xon_off` is 1, it requests nothing.
- R6: While `mac_busy` is high, no frame starts. A pending frame starts at the first clock edge at which `mac_busy` is low.
- R7: A single pending slot holds the most recent request. If several requests arrive in the same cycle, a pause request wins over a zero-time request, which wins over a refresh.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_last` and `tx_valid` hold.
- R9: When the last byte of a frame is accepted, the partner timer loads the frame's pause time times 64 and then counts down by one each cycle until it reaches zero. In a cycle where the count equals a nonzero `refresh_lead`, with `refresh_on` high, `xon_off` low and `fc_level` high, a frame carrying `pause_quanta` is requested.
- R10: With `xon_off` high, no refresh frame is requested even when `refresh_on` is set.
- R11: A request made while a pause frame is being sent is kept and sent right after that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_level | input | 1 | Level flow-control request pin |
| sw_pause | input | 1 | One-cycle software pause trigger |
| station_mac | input | 48 | Station source address, bits 47:40 sent first |
| pause_quanta | input | 16 | Pause time placed in pause frames |
| xon_off | input | 1 | 1 suppresses zero-time frames and refresh |
| refresh_on | input | 1 | Enables refresh frames before the partner's period ends |
| refresh_lead | input | 22 | Remaining-count value that triggers a refresh; 0 disables |
| mac_busy | input | 1 | MAC is sending a data packet; blocks a frame start |
| tx_ready | input | 1 | Downstream accepts the current byte |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Offered byte is the final FCS byte |

## Verification
A request seen at clock edge t fills the pending slot at t. The frame starts at edge t+1 if the path is free, so the first byte is visible after that edge. Bytes then advance one per accepted handshake. The partner timer reloads at the edge that accepts byte 63 and reaches the lead value a fixed number of edges later. The bench model steps the same edge-by-edge rules on the sampled inputs. It compares `tx_valid`, `tx_data` and `tx_last` on every falling clock edge, so outputs are judged half a cycle after each register update. Scenario checks then count the completed frames and read their pause-time fields from the captured stream.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int TIME_W      = 16;
  localparam int FRAME_BYTES = 64;
  localparam int BODY_BYTES  = 60;
  localparam int IDX_W       = $clog2(FRAME_BYTES);
  localparam logic [47:0] CTRL_DA = 48'h0180C2000001;

  // One byte of reflected CRC-32, LSB of the byte first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/pause_partner_timer.sv
module pause_partner_timer #(
  parameter int CNT_W = 22,
  parameter int QS    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [pause_pkg::TIME_W-1:0]  load_quanta,
  input  logic [CNT_W-1:0]              lead,
  output logic                          at_lead
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                cnt_d = {load_quanta, {QS{1'b0}}};
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_lead = (lead != '0) && (cnt_q == lead);
endmodule

// File: rtl/pause_req_ctl.sv
module pause_req_ctl #(
  parameter int CNT_W = 22,
  parameter int QS    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fc_level,
  input  logic                          sw_pause,
  input  logic [pause_pkg::TIME_W-1:0]  pause_quanta,
  input  logic                          xon_off,
  input  logic                          refresh_on,
  input  logic [CNT_W-1:0]              refresh_lead,
  input  logic                          mac_busy,
  input  logic                          tx_active,
  input  logic                          frame_done,
  input  logic [pause_pkg::TIME_W-1:0]  frame_quanta,
  output logic                          start,
  output logic [pause_pkg::TIME_W-1:0]  start_quanta
);
  import pause_pkg::*;

  logic              fc_q;
  logic              pend_q, pend_d;
  logic [TIME_W-1:0] ptime_q, ptime_d;
  logic              rise, fall, at_lead, refresh_req;

  pause_partner_timer #(.CNT_W(CNT_W), .QS(QS)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (frame_done),
    .load_quanta (frame_quanta),
    .lead        (refresh_lead),
    .at_lead     (at_lead)
  );

  assign rise        = fc_level & ~fc_q;
  assign fall        = ~fc_level & fc_q;
  assign refresh_req = refresh_on & ~xon_off & fc_level & at_lead;
  assign start       = pend_q & ~tx_active & ~mac_busy;
  assign start_quanta = ptime_q;

  // Later assignments take priority: pause > zero-time > refresh.
  always_comb begin
    pend_d  = pend_q;
    ptime_d = ptime_q;
    if (start) pend_d = 1'b0;
    if (refresh_req) begin
      pend_d  = 1'b1;
      ptime_d = pause_quanta;
    end
    if (fall && !xon_off) begin
      pend_d  = 1'b1;
      ptime_d = '0;
    end
    if (rise || sw_pause) begin
      pend_d  = 1'b1;
      ptime_d = pause_quanta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_q    <= 1'b0;
      pend_q  <= 1'b0;
      ptime_q <= '0;
    end else begin
      fc_q    <= fc_level;
      pend_q  <= pend_d;
      ptime_q <= ptime_d;
    end
  end
endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [pause_pkg::TIME_W-1:0]  start_quanta,
  input  logic [47:0]                   station_mac,
  input  logic                          tx_ready,
  output logic                          tx_valid,
  output logic [7:0]                    tx_data,
  output logic                          tx_last,
  output logic                          frame_done,
  output logic [pause_pkg::TIME_W-1:0]  frame_quanta
);
  import pause_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic              act_q, act_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [TIME_W-1:0] qt_q, qt_d;
  logic [31:0]       crc_q, crc_d;
  logic [7:0]        byte_c;
  logic              take, at_end;
  int                ii;

  assign take   = act_q & tx_ready;
  assign at_end = (idx_q == LAST_IDX);

  always_comb begin
    ii = int'(idx_q);
    if (ii < 6)                 byte_c = CTRL_DA[8*(5-ii) +: 8];
    else if (ii < 12)           byte_c = station_mac[8*(11-ii) +: 8];
    else if (ii == 12)          byte_c = 8'h88;
    else if (ii == 13)          byte_c = 8'h08;
    else if (ii == 14)          byte_c = 8'h00;
    else if (ii == 15)          byte_c = 8'h01;
    else if (ii == 16)          byte_c = qt_q[15:8];
    else if (ii == 17)          byte_c = qt_q[7:0];
    else if (ii < BODY_BYTES)   byte_c = 8'h00;
    else                        byte_c = ~crc_q[8*(ii-BODY_BYTES) +: 8];
  end

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    qt_d  = qt_q;
    crc_d = crc_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
      qt_d  = start_quanta;
      crc_d = '1;
    end else if (take) begin
      if (at_end) act_d = 1'b0;
      else        idx_d = idx_q + 1'b1;
      if (ii < BODY_BYTES) crc_d = crc32_step(crc_q, byte_c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      qt_q  <= '0;
      crc_q <= '0;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      qt_q  <= qt_d;
      crc_q <= crc_d;
    end
  end

  assign tx_valid     = act_q;
  assign tx_data      = byte_c;
  assign tx_last      = act_q & at_end;
  assign frame_done   = take & at_end;
  assign frame_quanta = qt_q;
endmodule

// File: rtl/pause_gen.sv
module pause_gen #(
  parameter int QS    = 6,
  parameter int CNT_W = pause_pkg::TIME_W + QS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_level,
  input  logic              sw_pause,
  input  logic [47:0]       station_mac,
  input  logic [15:0]       pause_quanta,
  input  logic              xon_off,
  input  logic              refresh_on,
  input  logic [CNT_W-1:0]  refresh_lead,
  input  logic              mac_busy,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last
);
  logic        start, frame_done;
  logic [15:0] start_quanta, frame_quanta;

  pause_req_ctl #(.CNT_W(CNT_W), .QS(QS)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fc_level     (fc_level),
    .sw_pause     (sw_pause),
    .pause_quanta (pause_quanta),
    .xon_off      (xon_off),
    .refresh_on   (refresh_on),
    .refresh_lead (refresh_lead),
    .mac_busy     (mac_busy),
    .tx_active    (tx_valid),
    .frame_done   (frame_done),
    .frame_quanta (frame_quanta),
    .start        (start),
    .start_quanta (start_quanta)
  );

  pause_frame_tx u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_quanta (start_quanta),
    .station_mac  (station_mac),
    .tx_ready     (tx_ready),
    .tx_valid     (tx_valid),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .frame_done   (frame_done),
    .frame_quanta (frame_quanta)
  );
endmodule

// File: rtl/pause_gen_checker.sv
module pause_gen_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mac_busy,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_last
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !tx_valid);

  assert_valid_until_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_valid) |-> $past(tx_last && tx_ready));

  assert_last_has_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  assert_no_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(!mac_busy));

  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));
endmodule

bind pause_gen pause_gen_checker u_pause_gen_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mac_busy (mac_busy),
  .tx_ready (tx_ready),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_last  (tx_last)
);

// File: tb/pause_gen_bench.sv
module pause_gen_bench;
  localparam int CW = 22;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic fc_level = 0, sw_pause = 0, xon_off = 0, refresh_on = 0, mac_busy = 0;
  logic tx_ready = 1;
  logic [47:0] station_mac = 48'h02A1B2C3D4E5;
  logic [15:0] pause_quanta = 16'h1234;
  logic [CW-1:0] refresh_lead = '0;
  logic tx_valid, tx_last;
  logic [7:0] tx_data;

  pause_gen u_pause_gen (
    .clk(clk), .rst_n(rst_n), .fc_level(fc_level), .sw_pause(sw_pause),
    .station_mac(station_mac), .pause_quanta(pause_quanta), .xon_off(xon_off),
    .refresh_on(refresh_on), .refresh_lead(refresh_lead), .mac_busy(mac_busy),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
  );

  int n_chk = 0, n_bad = 0;
  int ready_mode = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [7:0] b[64]);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int n = 0; n < 60; n++) begin
      c = c ^ {24'd0, b[n]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // ---------------- reference model ----------------
  bit m_fcq, m_pend, m_act;
  logic [15:0] m_pt, m_ft;
  int m_idx;
  longint m_cnt;
  logic [7:0] m_frame[64];

  task automatic build(input logic [15:0] t);
    logic [31:0] c;
    logic [47:0] da = 48'h0180C2000001;
    for (int n = 0; n < 64; n++) m_frame[n] = 8'h00;
    for (int n = 0; n < 6; n++) begin
      m_frame[n]   = da[47-8*n -: 8];
      m_frame[6+n] = station_mac[47-8*n -: 8];
    end
    m_frame[12] = 8'h88; m_frame[13] = 8'h08; m_frame[14] = 8'h00; m_frame[15] = 8'h01;
    m_frame[16] = t[15:8]; m_frame[17] = t[7:0];
    c = ref_crc(m_frame);
    for (int n = 0; n < 4; n++) m_frame[60+n] = c[8*n +: 8];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fcq = 0; m_pend = 0; m_act = 0; m_pt = 0; m_ft = 0; m_idx = 0; m_cnt = 0;
    end else begin
      bit rise, fall, refr, fin, go;
      rise = fc_level && !m_fcq;
      fall = !fc_level && m_fcq;
      refr = refresh_on && !xon_off && fc_level && (refresh_lead != 0) && (m_cnt == longint'(refresh_lead));
      fin  = m_act && tx_ready && (m_idx == 63);
      go   = !m_act && m_pend && !mac_busy;
      if (go) begin
        m_act = 1; m_idx = 0; m_ft = m_pt; build(m_pt); m_pend = 0;
      end else if (m_act && tx_ready) begin
        if (m_idx == 63) m_act = 0; else m_idx++;
      end
      if (refr) begin m_pend = 1; m_pt = pause_quanta; end
      if (fall && !xon_off) begin m_pend = 1; m_pt = 0; end
      if (rise || sw_pause) begin m_pend = 1; m_pt = pause_quanta; end
      if (fin) m_cnt = longint'(m_ft) * 64;
      else if (m_cnt != 0) m_cnt--;
      m_fcq = fc_level;
    end
  end

  // ---------------- compare and monitor ----------------
  logic [7:0] cap[64];
  int ci = 0;
  int frames = 0;
  logic [15:0] got_t[$];
  bit prev_stall = 0;
  logic [7:0] prev_data;

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk(tx_valid == m_act, "R4", "tx_valid vs model", tx_valid, m_act);
      if (m_act) begin
        chk(tx_data == m_frame[m_idx], "R2", $sformatf("byte %0d", m_idx), tx_data, m_frame[m_idx]);
        chk(tx_last == (m_idx == 63), "R3", "tx_last position", tx_last, m_idx == 63);
      end
      if (prev_stall) chk(tx_valid && tx_data == prev_data, "R8", "stalled byte held", tx_data, prev_data);
      tx_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        cap[ci] = tx_data;
        if (tx_last) begin
          bit hok = 1;
          logic [31:0] c;
          logic [47:0] da = 48'h0180C2000001;
          for (int n = 0; n < 6; n++) begin
            if (cap[n] != da[47-8*n -: 8]) hok = 0;
            if (cap[6+n] != station_mac[47-8*n -: 8]) hok = 0;
          end
          if (cap[12] != 8'h88 || cap[13] != 8'h08 || cap[14] != 8'h00 || cap[15] != 8'h01) hok = 0;
          for (int n = 18; n < 60; n++) if (cap[n] != 0) hok = 0;
          chk(ci == 63, "R2", "frame length-1", ci, 63);
          chk(hok, "R2", "header and padding", hok, 1);
          c = ref_crc(cap);
          chk({cap[63], cap[62], cap[61], cap[60]} == c, "R3", "FCS",
              {cap[63], cap[62], cap[61], cap[60]}, c);
          got_t.push_back({cap[16], cap[17]});
          frames++;
          ci = 0;
        end else ci++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    tick(2);
    while ((m_act || m_pend) && g < 5000) begin tick(1); g++; end
    tick(2);
  endtask

  task automatic pulse_sw();
    sw_pause = 1; tick(1); sw_pause = 0;
  endtask

  task automatic finish_up();
    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int c0;
    while (1) begin
      @(negedge clk);
      c0++;
      if (c0 > 150000) begin
        chk(0, "R1", "watchdog expired", c0, 150000);
        finish_up();
      end
    end
  end

  initial begin
    int f0;
    tick(3);
    chk(tx_valid == 0, "R1", "valid during reset", tx_valid, 0);
    rst_n = 1;
    tick(6);
    chk(tx_valid == 0, "R1", "valid idle after reset", tx_valid, 0);

    // R4: software trigger, start timing
    f0 = frames;
    sw_pause = 1; tick(1); sw_pause = 0;
    chk(tx_valid == 0, "R4", "one edge after trigger", tx_valid, 0);
    tick(1);
    chk(tx_valid == 1, "R4", "two edges after trigger", tx_valid, 1);
    wait_idle();
    chk(frames == f0 + 1, "R4", "frames from sw trigger", frames - f0, 1);
    chk(got_t[$] == 16'h1234, "R4", "pause time", got_t[$], 16'h1234);

    // R5/R8: pin rise then fall, random ready
    ready_mode = 1; pause_quanta = 16'h00A5; station_mac = 48'hFEDCBA987654;
    f0 = frames;
    fc_level = 1; wait_idle();
    chk(frames == f0 + 1 && got_t[$] == 16'h00A5, "R4", "pin rise frame", got_t[$], 16'h00A5);
    fc_level = 0; wait_idle();
    chk(frames == f0 + 2, "R5", "XON frame count", frames - f0, 2);
    chk(got_t[$] == 16'h0000, "R5", "XON zero time", got_t[$], 0);

    // R5: XON suppressed
    ready_mode = 0; xon_off = 1; f0 = frames;
    fc_level = 1; wait_idle(); fc_level = 0; wait_idle(); tick(20);
    chk(frames == f0 + 1, "R5", "XON suppressed", frames - f0, 1);
    xon_off = 0;

    // R6/R7: busy holds, latest wins
    mac_busy = 1; f0 = frames;
    pause_quanta = 16'h0111; pulse_sw(); tick(3);
    pause_quanta = 16'h0222; pulse_sw(); tick(5);
    chk(tx_valid == 0, "R6", "no start while busy", tx_valid, 0);
    mac_busy = 0; tick(1);
    chk(tx_valid == 1, "R6", "start after busy drops", tx_valid, 1);
    wait_idle();
    chk(frames == f0 + 1, "R7", "one frame for two requests", frames - f0, 1);
    chk(got_t[$] == 16'h0222, "R7", "latest request kept", got_t[$], 16'h0222);

    mac_busy = 1; f0 = frames;
    fc_level = 1; tick(3); fc_level = 0; tick(3);
    mac_busy = 0; wait_idle();
    chk(frames == f0 + 1 && got_t[$] == 0, "R7", "XON overwrote pause", got_t[$], 0);

    // R11: request during own frame
    f0 = frames; pause_quanta = 16'h0333; pulse_sw(); tick(10);
    pause_quanta = 16'h0444; pulse_sw(); wait_idle();
    chk(frames == f0 + 2, "R11", "two frames", frames - f0, 2);
    chk(got_t[$] == 16'h0444, "R11", "held frame time", got_t[$], 16'h0444);

    // R10: refresh blocked by xon_off
    refresh_on = 1; refresh_lead = 22'd20; pause_quanta = 16'h0002; xon_off = 1;
    f0 = frames; fc_level = 1; tick(400);
    chk(frames == f0 + 1, "R10", "no refresh with xon_off", frames - f0, 1);
    fc_level = 0; wait_idle(); tick(200);
    xon_off = 0;

    // R9: refresh while pin held
    f0 = frames; fc_level = 1; tick(400);
    chk(frames >= f0 + 2, "R9", "refresh frames sent", frames - f0, 2);
    chk(got_t[$] == 16'h0002, "R9", "refresh time", got_t[$], 2);
    fc_level = 0; wait_idle();
    chk(frames >= f0 + 3 && got_t[$] == 0, "R9", "XON after refresh run", got_t[$], 0);

    tick(5);
    finish_up();
  end
endmodule